// File: doc/BRIEF.md
# Two-Wire Serial Slave with Auto-Incrementing Control Register Bank

This block sits on a two-wire I2C bus as a slave. It gives a bus master access to a bank of 32 eight-bit control registers. Every register's contents are driven onto a flat output vector, so the rest of the chip sees each setting at all times. SCL and SDA are oversampled with the system clock. The block never drives SDA high. It only pulls the line low through an open-drain enable, and the pad or board supplies the pull-up.

The slave answers to the fixed 7-bit address 1011111. In a write, the byte after the address sets an internal register pointer. Each data byte that follows lands at the pointer, and the pointer then steps by one. In a read, the slave sends bytes from the pointer onward and steps after each one. The master's acknowledge continues the read and its not-acknowledge ends it. A repeated START sends the slave back to address matching but leaves the pointer where it was. A master can therefore set the pointer in a write and then read from that spot in the same transfer.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset every register holds 0x00 and SDA is released (`sda_pull_low` = 0).
- R2: An address byte whose upper seven bits are 1011111 is acknowledged by pulling SDA low during the ninth SCL pulse. Its last bit selects the direction: 0 = write (slave receives), 1 = read (slave transmits).
- R3: With any other address, the slave acknowledges nothing and changes no register until the next START. The same holds for bytes clocked after a STOP. During this time SDA stays released.
- R4: In a write, the first byte after the address is the subaddress. Its low five bits load the register pointer, and the slave acknowledges it.
- R5: Each data byte of a write is acknowledged and stored at the pointer. The pointer then advances by one, wrapping from 31 to 0.
- R6: In a read, the slave sends the register at the pointer, most significant bit first, with SDA changing only while SCL is low. The pointer advances by one for each byte sent. A master acknowledge (SDA low on the ninth pulse) makes the slave send the next register.
- R7: A master not-acknowledge (SDA high on the ninth pulse) ends the read. The slave then keeps SDA released until the next START.
- R8: A repeated START returns the slave to address matching without changing the pointer.
- R9: A START arriving in the middle of a byte discards the bits received so far, and no register is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_low | output | 1 | Open-drain enable: 1 pulls SDA low, 0 releases it |
| ctrl_regs | output | 256 | All registers, register i at bits [8*i+7:8*i] |

## Verification
Two events can land in the same sampled cycle. One is a START condition. The other is the shift of a byte that is still incomplete, or a pointer step as it wraps from 31 to 0. The bench provokes the first case by issuing a START after four bits of a data byte. It judges the result by checking that the register the partial byte pointed at is unchanged and that the following address is still acknowledged. It provokes the wrap by writing two bytes starting at subaddress 31, and by random writes whose runs cross the top of the bank. It judges the wrap by comparing the full register vector against a bench model after every transfer.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;

    // Phase of the byte engine
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,   // not addressed, bus ignored
        ST_RX     = 3'd1,   // shifting in a byte from the master
        ST_ACK_TX = 3'd2,   // slave holds SDA low for the acknowledge
        ST_TX     = 3'd3,   // shifting a register byte out
        ST_ACK_RX = 3'd4    // sampling the master's acknowledge
    } eng_state_e;

    // Meaning of the byte being received
    typedef enum logic [1:0] {
        K_ADDR = 2'd0,
        K_SUB  = 2'd1,
        K_DATA = 2'd2
    } byte_kind_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_regbank_sync.sv
// Two-flop synchroniser for SCL/SDA plus edge and START/STOP detection.
module i2c_regbank_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [1:0] scl_ff;
        logic [1:0] sda_ff;
        logic       scl_prev;
        logic       sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  scl_s;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_ff   = {sync_q.scl_ff[0], scl_i};
        sync_d.sda_ff   = {sync_q.sda_ff[0], sda_i};
        sync_d.scl_prev = sync_q.scl_ff[1];
        sync_d.sda_prev = sync_q.sda_ff[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;   // idle bus: both lines high
        else        sync_q <= sync_d;
    end

    assign scl_s     = sync_q.scl_ff[1];
    assign sda_s     = sync_q.sda_ff[1];
    assign scl_rise  = scl_s & ~sync_q.scl_prev;
    assign scl_fall  = ~scl_s & sync_q.scl_prev;
    assign start_det = scl_s & sync_q.scl_prev & sync_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & sync_q.scl_prev & ~sync_q.sda_prev & sda_s;

endmodule

// File: rtl/i2c_regbank_mem.sv
// Register bank: one write port, one combinational read port, all contents exposed.
module i2c_regbank_mem #(
    parameter int NREG = 32,
    localparam int PW  = $clog2(NREG)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we,
    input  logic [PW-1:0]                        waddr,
    input  logic [i2c_regbank_pkg::BYTE_W-1:0]   wdata,
    input  logic [PW-1:0]                        raddr,
    output logic [i2c_regbank_pkg::BYTE_W-1:0]   rdata,
    output logic [NREG*i2c_regbank_pkg::BYTE_W-1:0] regs_o
);

    import i2c_regbank_pkg::*;

    logic [BYTE_W-1:0] mem_d [NREG];
    logic [BYTE_W-1:0] mem_q [NREG];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_o[g*BYTE_W +: BYTE_W] = mem_q[g];
    end

endmodule

// File: rtl/i2c_regbank_fsm.sv
// Byte-level protocol engine: address match, subaddress, data, acknowledge.
module i2c_regbank_fsm #(
    parameter int           NREG     = 32,
    parameter logic [6:0]   DEV_ADDR = 7'b1011111,
    localparam int          PW       = $clog2(NREG)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                sda_s,
    input  logic                                scl_rise,
    input  logic                                scl_fall,
    input  logic                                start_det,
    input  logic                                stop_det,
    input  logic [i2c_regbank_pkg::BYTE_W-1:0]  rd_data,
    output logic                                drive_o,
    output logic [PW-1:0]                       ptr_o,
    output logic                                we_o,
    output logic [PW-1:0]                       waddr_o,
    output logic [i2c_regbank_pkg::BYTE_W-1:0]  wdata_o,
    output i2c_regbank_pkg::eng_state_e         state_o,
    output logic                                nack_o
);

    import i2c_regbank_pkg::*;

    typedef struct packed {
        eng_state_e        st;
        byte_kind_e        kind;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [PW-1:0]     ptr;
        logic              rw;
        logic              nack;
        logic              drive;
        logic              we;
        logic [PW-1:0]     wa;
        logic [BYTE_W-1:0] wd;
    } eng_t;

    localparam eng_t ENG_RST = '{st: ST_IDLE, kind: K_ADDR, default: '0};

    eng_t eng_d, eng_q;
    logic [BYTE_W-1:0] byte_in;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(NREG - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        eng_d    = eng_q;
        eng_d.we = 1'b0;
        byte_in  = {eng_q.sh[BYTE_W-2:0], sda_s};

        if (start_det) begin
            // (repeated) START: expect an address, pointer untouched
            eng_d.st    = ST_RX;
            eng_d.kind  = K_ADDR;
            eng_d.cnt   = '0;
            eng_d.drive = 1'b0;
            eng_d.nack  = 1'b0;
        end else if (stop_det) begin
            eng_d.st    = ST_IDLE;
            eng_d.drive = 1'b0;
        end else begin
            unique case (eng_q.st)
                ST_RX: begin
                    if (scl_rise && eng_q.cnt != 4'd8) begin
                        eng_d.sh  = byte_in;
                        eng_d.cnt = eng_q.cnt + 4'd1;
                        if (eng_q.cnt == 4'd7) begin
                            if (eng_q.kind == K_SUB) begin
                                eng_d.ptr = byte_in[PW-1:0];
                            end else if (eng_q.kind == K_DATA) begin
                                eng_d.we  = 1'b1;
                                eng_d.wa  = eng_q.ptr;
                                eng_d.wd  = byte_in;
                                eng_d.ptr = step(eng_q.ptr);
                            end
                        end
                    end else if (scl_fall && eng_q.cnt == 4'd8) begin
                        if (eng_q.kind != K_ADDR || eng_q.sh[7:1] == DEV_ADDR) begin
                            eng_d.st    = ST_ACK_TX;
                            eng_d.drive = 1'b1;
                            if (eng_q.kind == K_ADDR) eng_d.rw = eng_q.sh[0];
                        end else begin
                            eng_d.st = ST_IDLE;
                        end
                    end
                end
                ST_ACK_TX: begin
                    if (scl_fall) begin
                        eng_d.cnt = '0;
                        if (eng_q.kind == K_ADDR && eng_q.rw) begin
                            eng_d.st    = ST_TX;
                            eng_d.sh    = rd_data;
                            eng_d.ptr   = step(eng_q.ptr);
                            eng_d.drive = ~rd_data[BYTE_W-1];
                        end else begin
                            eng_d.st    = ST_RX;
                            eng_d.drive = 1'b0;
                            eng_d.kind  = (eng_q.kind == K_ADDR) ? K_SUB : K_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (eng_q.cnt == 4'd7) begin
                            eng_d.st    = ST_ACK_RX;
                            eng_d.drive = 1'b0;
                        end else begin
                            eng_d.cnt   = eng_q.cnt + 4'd1;
                            eng_d.sh    = {eng_q.sh[BYTE_W-2:0], 1'b0};
                            eng_d.drive = ~eng_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_ACK_RX: begin
                    if (scl_rise) begin
                        eng_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (eng_q.nack) begin
                            eng_d.st = ST_IDLE;
                        end else begin
                            eng_d.st    = ST_TX;
                            eng_d.cnt   = '0;
                            eng_d.sh    = rd_data;
                            eng_d.ptr   = step(eng_q.ptr);
                            eng_d.drive = ~rd_data[BYTE_W-1];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= ENG_RST;
        else        eng_q <= eng_d;
    end

    assign drive_o = eng_q.drive;
    assign ptr_o   = eng_q.ptr;
    assign we_o    = eng_q.we;
    assign waddr_o = eng_q.wa;
    assign wdata_o = eng_q.wd;
    assign state_o = eng_q.st;
    assign nack_o  = eng_q.nack;

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
    parameter int         NREG     = 32,
    parameter logic [6:0] DEV_ADDR = 7'b1011111,
    localparam int        PW       = $clog2(NREG)
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     scl_i,
    input  logic                                     sda_i,
    output logic                                     sda_pull_low,
    output logic [NREG*i2c_regbank_pkg::BYTE_W-1:0]  ctrl_regs
);

    import i2c_regbank_pkg::*;

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rd_data, wr_data;
    logic [PW-1:0]     eng_ptr, wr_addr;
    logic              wr_en, eng_nack;
    eng_state_e        eng_state;

    i2c_regbank_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_regbank_fsm #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .drive_o   (sda_pull_low),
        .ptr_o     (eng_ptr),
        .we_o      (wr_en),
        .waddr_o   (wr_addr),
        .wdata_o   (wr_data),
        .state_o   (eng_state),
        .nack_o    (eng_nack)
    );

    i2c_regbank_mem #(.NREG(NREG)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en),
        .waddr  (wr_addr),
        .wdata  (wr_data),
        .raddr  (eng_ptr),
        .rdata  (rd_data),
        .regs_o (ctrl_regs)
    );

endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk #(
    parameter int  NREG = 32,
    localparam int PW   = $clog2(NREG)
) (
    input logic                            clk,
    input logic                            rst_n,
    input i2c_regbank_pkg::eng_state_e     state,
    input logic                            sda_pull_low,
    input logic                            start_det,
    input logic                            stop_det,
    input logic                            scl_fall,
    input logic                            nack,
    input logic [PW-1:0]                   ptr,
    input logic                            wr_en,
    input logic [PW-1:0]                   wr_addr
);

    import i2c_regbank_pkg::*;

    function automatic logic [PW-1:0] next_of(input logic [PW-1:0] p);
        return (p == PW'(NREG - 1)) ? '0 : p + 1'b1;
    endfunction

    // R3: an unaddressed slave leaves SDA alone
    assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull_low);

    // R2: SDA is pulled only while acknowledging or sending a byte
    assert_pull_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_low |-> (state == ST_ACK_TX || state == ST_TX));

    // R5: each stored byte leaves the pointer one past its address, wrapping
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ptr == next_of(wr_addr)));

    // R8: a START never moves the pointer and re-arms address reception
    assert_start_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RX && $stable(ptr)));

    // R7: a not-acknowledge from the master ends the read
    assert_nack_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK_RX && scl_fall && nack && !start_det && !stop_det)
        |=> (state == ST_IDLE && !sda_pull_low));

endmodule

bind i2c_regbank_slave i2c_regbank_chk #(.NREG(NREG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (eng_state),
    .sda_pull_low (sda_pull_low),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .scl_fall     (scl_fall),
    .nack         (eng_nack),
    .ptr          (eng_ptr),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr)
);

// File: tb/sim_i2c_regbank_slave.sv
module sim_i2c_regbank_slave;

    localparam int         NREG = 32;
    localparam int         Q    = 8;          // clocks per quarter bus bit
    localparam logic [6:0] DEV  = 7'b1011111;

    logic             clk   = 1'b0;
    logic             rst_n = 1'b0;
    logic             scl_m = 1'b1;
    logic             sda_m = 1'b1;
    logic             sda_pull;
    logic             sda_bus;
    logic [NREG*8-1:0] regs;

    assign sda_bus = sda_m & ~sda_pull;   // wired-AND open-drain line

    always #4 clk = ~clk;                 // 125 MHz

    i2c_regbank_slave u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_pull_low (sda_pull),
        .ctrl_regs    (regs)
    );

    int          n_chk  = 0;
    int          n_fail = 0;
    logic        done   = 1'b0;
    logic [7:0]  model [NREG];
    logic [4:0]  mptr;
    logic [7:0]  wbuf  [4];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int bank_mismatches();
        int m = 0;
        for (int i = 0; i < NREG; i++)
            if (regs[i*8 +: 8] !== model[i]) m++;
        return m;
    endfunction

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0; wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        ack = sda_bus;
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic master_nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl_m = 1'b1; wq();
            b[i] = sda_bus;
            wq();
            scl_m = 1'b0;
        end
        wq();
        sda_m = master_nack; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    // START, address+W, subaddress; no STOP so a read may follow
    task automatic set_ptr(input logic [7:0] sub);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a); chk("R2 write address acked", a, 1'b0);
        send_byte(sub, a);         chk("R4 subaddress acked", a, 1'b0);
        mptr = sub[4:0];
    endtask

    task automatic do_write(input logic [7:0] sub, input int n);
        logic a;
        set_ptr(sub);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            chk("R5 data byte acked", a, 1'b0);
            model[mptr] = wbuf[i];
            mptr = mptr + 5'd1;
        end
        bus_stop();
        chk("R5 bank after write", bank_mismatches(), 0);
    endtask

    task automatic do_read(input int n);
        logic       a;
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b1}, a); chk("R2 read address acked", a, 1'b0);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b);
            chk("R6 read byte", b, model[mptr]);
            mptr = mptr + 5'd1;
        end
    endtask

    initial begin
        logic       a;
        logic [7:0] b;
        void'($urandom(32'd7405));
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        mptr = '0;

        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 registers clear", bank_mismatches(), 0);
        chk("R1 SDA released", sda_pull, 1'b0);

        // R4/R5: basic write of two bytes
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
        do_write(8'h03, 2);
        chk("R5 reg4 holds second byte", regs[4*8 +: 8], 8'h3C);

        // R3: foreign address, nothing acked or written
        bus_start();
        send_byte({7'h50, 1'b0}, a); chk("R3 foreign address not acked", a, 1'b1);
        send_byte(8'h02, a);         chk("R3 byte after foreign address", a, 1'b1);
        send_byte(8'h99, a);         chk("R3 data after foreign address", a, 1'b1);
        bus_stop();
        chk("R3 bank unchanged", bank_mismatches(), 0);
        // R3: byte after STOP without a START is ignored
        send_byte(8'hBE, a);         chk("R3 byte after STOP not acked", a, 1'b1);
        bus_stop();
        chk("R3 bank unchanged after STOP", bank_mismatches(), 0);

        // R5: wrap from 31 to 0; upper subaddress bits dropped (R4)
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        do_write(8'hFF, 2);
        chk("R5 reg31 written", regs[31*8 +: 8], 8'h11);
        chk("R5 wrap to reg0", regs[0 +: 8], 8'h22);

        // R6/R7: set pointer, repeated START, read three, NACK last
        set_ptr(8'h03);
        do_read(3);
        recv_byte(1'b1, b);
        chk("R7 released after NACK", b, 8'hFF);
        chk("R7 SDA not pulled", sda_pull, 1'b0);
        bus_stop();

        // R6: pointer persists across STOP (next is reg6)
        do_read(1);
        bus_stop();

        // R8: repeated START keeps the pointer after a write
        set_ptr(8'h0C);
        send_byte(8'h5A, a); chk("R5 data acked", a, 1'b0);
        model[12] = 8'h5A; mptr = 5'd13;
        model[13] = 8'h6B;
        bus_stop();
        wbuf[0] = 8'h6B;
        do_write(8'h0D, 1);
        set_ptr(8'h0C);
        send_byte(8'h5A, a);
        mptr = 5'd13;
        bus_start();
        send_byte({DEV, 1'b1}, a); chk("R8 address after repeated START", a, 1'b0);
        recv_byte(1'b1, b);
        chk("R8 read from kept pointer", b, 8'h6B);
        bus_stop();

        // R9: START in mid-byte discards the partial byte
        set_ptr(8'h0A);
        send_byte(8'h77, a); chk("R5 data acked", a, 1'b0);
        model[10] = 8'h77;
        send_bits(8'h0F, 4);
        bus_start();
        send_byte({DEV, 1'b0}, a); chk("R9 address acked after mid-byte START", a, 1'b0);
        send_byte(8'h14, a);       chk("R4 subaddress acked", a, 1'b0);
        send_byte(8'h42, a);       chk("R5 data acked", a, 1'b0);
        model[20] = 8'h42;
        bus_stop();
        chk("R9 partial byte not stored", regs[11*8 +: 8], model[11]);
        chk("R9 bank after abort", bank_mismatches(), 0);

        // Random writes and reads against the model
        for (int t = 0; t < 16; t++) begin
            int n = $urandom_range(1, 4);
            for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
            do_write(8'($urandom), n);
        end
        for (int t = 0; t < 8; t++) begin
            set_ptr(8'($urandom));
            do_read($urandom_range(1, 4));
            bus_stop();
        end
        chk("R1 SDA released at end", sda_pull, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule